// File: doc/BRIEF.md
# Bus-Snooping Monochrome Video Serializer

This block sits beside an 8-bit processor bus and turns the processor's own memory reads into a one-bit video stream. The processor and the pixel path share a single clock. Every clock is one bus cycle. On each cycle the block decodes the address and the direction. When the processor reads a byte from the upper three quarters of the address space, the block captures that byte from the data bus into an 8-bit shift register. The register then emits one pixel per clock, most significant bit first. A program that issues one graphics read every eight clocks therefore yields an unbroken pixel line. Eighty such reads fill a 640-pixel line.

Horizontal and vertical sync come from two flip-flops that the processor writes through a fixed I/O address in low memory. The block holds no line or frame counters. Software paces the 800-clock line and the 525-line frame by writing those flip-flops at the right moments. Between loads the shift register fills with zeros, so the screen is black during blanking.

Top module: `vid_snoop_serializer`

## Requirements
- R1: A read cycle (`cpu_rd`=1) whose address has bit 15 or bit 14 set (0x4000 to 0xFFFF) loads `cpu_data` into the shift register on the clock edge that ends the cycle. Bit 7 of that byte appears on `pix_out` from that edge until the next one.
- R2: After a load, `pix_out` presents the byte's bits in the order 7, 6, ..., 0, one per clock, on consecutive clocks.
- R3: When no new load occurs, zeros shift in. `pix_out` is 0 from the ninth clock after the last load onward.
- R4: A read anywhere in 0x0000 to 0x3FFF never loads the shift register.
- R5: A write cycle (`cpu_rd`=0) to 0x4000 to 0xFFFF never loads the shift register.
- R6: A qualifying read that arrives while earlier bits remain unsent replaces them. The new byte's bit 7 follows at once.
- R7: A write to address 0x3FFF copies data bit 0 to `hsync_n` and data bit 1 to `vsync_n` on the ending edge. Data bits 7 to 2 have no effect.
- R8: Writes to any other address, and reads of 0x3FFF, leave both sync outputs unchanged.
- R9: While `rst` is high at a clock edge, the shift register clears and both sync outputs go to 1, which is the inactive level. `rst` has priority over any bus cycle in the same clock.
- R10: Eighty graphics reads spaced eight clocks apart produce 640 consecutive pixels with no gap. The pixels match the bytes in read order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared processor and pixel clock; one bus cycle per edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | Processor address bus |
| cpu_data | input | 8 | Processor data bus, sampled at the end of the cycle |
| cpu_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| pix_out | output | 1 | Monochrome pixel, 1 = lit |
| hsync_n | output | 1 | Horizontal sync flip-flop output, active low |
| vsync_n | output | 1 | Vertical sync flip-flop output, active low |

## Verification
Some rules are checked by assertions on every cycle:
- a graphics read puts the captured byte's top bit on the pixel pin in the next cycle;
- an all-zero register stays dark without a load;
- a program-space read is never decoded as a load;
- the sync flip-flops follow a write to the I/O address and hold otherwise;
- reset forces the idle state.

Other behaviour can only be shown by the bench's scenarios:
- the full bit order of a byte;
- the way a mid-byte reload replaces the remaining bits;
- a gap-free 640-pixel line from 80 spaced loads;
- the way the data bits above bit 1 are ignored on the sync write.

A random stream that mixes the address classes compares every output against a bench model in every cycle.

// File: rtl/vid_snoop_pkg.sv
package vid_snoop_pkg;

    // Classification of one bus cycle by the address decoder
    typedef enum logic [1:0] {
        CYC_NONE    = 2'd0,
        CYC_GFX_RD  = 2'd1,
        CYC_SYNC_WR = 2'd2
    } cyc_kind_e;

endpackage

// File: rtl/vid_bus_decode.sv
module vid_bus_decode
    import vid_snoop_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] GFX_MASK  = 16'hC000,
    parameter logic [15:0] SYNC_ADDR = 16'h3FFF
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    output cyc_kind_e         kind_o
);

    localparam logic [ADDR_W-1:0] MASK_L = ADDR_W'(GFX_MASK);
    localparam logic [ADDR_W-1:0] SYNC_L = ADDR_W'(SYNC_ADDR);

    logic in_gfx;
    logic at_sync;

    always_comb begin
        in_gfx  = |(addr_i & MASK_L);
        at_sync = (addr_i == SYNC_L);
        kind_o  = CYC_NONE;
        if (rd_i && in_gfx) begin
            kind_o = CYC_GFX_RD;
        end else if (!rd_i && at_sync) begin
            kind_o = CYC_SYNC_WR;
        end
    end

endmodule

// File: rtl/vid_pixel_shifter.sv
module vid_pixel_shifter #(
    parameter int DATA_W    = 8,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              pix_o
);

    localparam int FIRST_IDX = MSB_FIRST ? DATA_W - 1 : 0;

    typedef struct packed {
        logic [DATA_W-1:0] sh;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic [DATA_W-1:0] shifted;

    generate
        if (MSB_FIRST) begin : g_msb
            assign shifted = {st_q.sh[DATA_W-2:0], 1'b0};
        end else begin : g_lsb
            assign shifted = {1'b0, st_q.sh[DATA_W-1:1]};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.sh = '0;
        end else if (load_i) begin
            st_d.sh = data_i;
        end else begin
            st_d.sh = shifted;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pix_o = st_q.sh[FIRST_IDX];

    // R1
    load_first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (pix_o == $past(data_i[FIRST_IDX])));

    // R3
    dark_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && st_q.sh == '0) |=> (pix_o == 1'b0));

    // R9
    shift_reset_chk: assert property (@(posedge clk)
        rst |=> (st_q.sh == '0));

endmodule

// File: rtl/vid_sync_regs.sv
module vid_sync_regs (
    input  logic clk,
    input  logic rst,
    input  logic wr_i,
    input  logic hs_val_i,
    input  logic vs_val_i,
    output logic hs_o,
    output logic vs_o
);

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.hs = 1'b1;
            st_d.vs = 1'b1;
        end else if (wr_i) begin
            st_d.hs = hs_val_i;
            st_d.vs = vs_val_i;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign hs_o = st_q.hs;
    assign vs_o = st_q.vs;

    // R7
    sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (hs_o == $past(hs_val_i) && vs_o == $past(vs_val_i)));

    // R8
    sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> ($stable(hs_o) && $stable(vs_o)));

    // R9
    sync_reset_chk: assert property (@(posedge clk)
        rst |=> (hs_o && vs_o));

endmodule

// File: rtl/vid_snoop_serializer.sv
module vid_snoop_serializer
    import vid_snoop_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] GFX_MASK  = 16'hC000,
    parameter logic [15:0] SYNC_ADDR = 16'h3FFF,
    parameter int          HS_BIT    = 0,
    parameter int          VS_BIT    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_rd,
    output logic              pix_out,
    output logic              hsync_n,
    output logic              vsync_n
);

    localparam logic [ADDR_W-1:0] MASK_L = ADDR_W'(GFX_MASK);

    cyc_kind_e kind;

    vid_bus_decode #(
        .ADDR_W   (ADDR_W),
        .GFX_MASK (GFX_MASK),
        .SYNC_ADDR(SYNC_ADDR)
    ) u_decode (
        .addr_i(cpu_addr),
        .rd_i  (cpu_rd),
        .kind_o(kind)
    );

    vid_pixel_shifter #(
        .DATA_W   (DATA_W),
        .MSB_FIRST(1'b1)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .load_i(kind == CYC_GFX_RD),
        .data_i(cpu_data),
        .pix_o (pix_out)
    );

    vid_sync_regs u_sync (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (kind == CYC_SYNC_WR),
        .hs_val_i(cpu_data[HS_BIT]),
        .vs_val_i(cpu_data[VS_BIT]),
        .hs_o    (hsync_n),
        .vs_o    (vsync_n)
    );

    // R4
    prog_read_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && ((cpu_addr & MASK_L) == '0)) |-> (kind != CYC_GFX_RD));

    // R5
    gfx_write_no_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_rd) |-> (kind != CYC_GFX_RD));

endmodule

// File: tb/test_vid_snoop_serializer.sv
module test_vid_snoop_serializer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_rd = 1'b1;
    logic        pix_out, hsync_n, vsync_n;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_sh = 8'h00;
    logic       m_hs = 1'b1;
    logic       m_vs = 1'b1;

    always #4 clk = ~clk;

    vid_snoop_serializer i_vid_snoop_serializer (
        .clk     (clk),
        .rst     (rst),
        .cpu_addr(cpu_addr),
        .cpu_data(cpu_data),
        .cpu_rd  (cpu_rd),
        .pix_out (pix_out),
        .hsync_n (hsync_n),
        .vsync_n (vsync_n)
    );

    // Model of the pixel register per R1-style rules: load on graphics read, else shift in zero
    function automatic logic [7:0] exp_shift(logic [7:0] sh, logic [15:0] a,
                                             logic [7:0] d, logic rd, logic r);
        if (r) return 8'h00;
        if (rd && (a[15] || a[14])) return d;
        return {sh[6:0], 1'b0};
    endfunction

    function automatic logic [1:0] exp_sync(logic [1:0] hv, logic [15:0] a,
                                            logic [7:0] d, logic rd, logic r);
        if (r) return 2'b11;
        if (!rd && a == 16'h3FFF) return {d[0], d[1]};
        return hv;
    endfunction

    task automatic check3(string tag, logic ep, logic eh, logic ev);
        checks++;
        if (pix_out !== ep || hsync_n !== eh || vsync_n !== ev) begin
            errors++;
            $display("FAIL %s: pix/hs/vs actual %b%b%b expected %b%b%b",
                     tag, pix_out, hsync_n, vsync_n, ep, eh, ev);
        end
    endtask

    // One bus cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(logic [15:0] a, logic [7:0] d, logic rd, logic r, string tag);
        logic [1:0] hv;
        cpu_addr = a;
        cpu_data = d;
        cpu_rd   = rd;
        rst      = r;
        @(posedge clk);
        m_sh = exp_shift(m_sh, a, d, rd, r);
        hv   = exp_sync({m_hs, m_vs}, a, d, rd, r);
        m_hs = hv[1];
        m_vs = hv[0];
        @(negedge clk);
        check3(tag, m_sh[7], m_hs, m_vs);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(16'h0100, 8'hFF, 1'b1, 1'b0, tag);
    endtask

    // Directed literal check of a byte streamed after a load
    task automatic byte_out(logic [15:0] a, logic [7:0] b);
        cyc(a, b, 1'b1, 1'b0, "R1");
        checks++;
        if (pix_out !== b[7]) begin
            errors++;
            $display("FAIL R1: first pixel actual %b expected %b", pix_out, b[7]);
        end
        for (int k = 6; k >= 0; k--) begin
            cyc(16'h0200, 8'hFF, 1'b1, 1'b0, "R2");
            checks++;
            if (pix_out !== b[k]) begin
                errors++;
                $display("FAIL R2: bit %0d actual %b expected %b", k, pix_out, b[k]);
            end
        end
        cyc(16'h0200, 8'hFF, 1'b1, 1'b0, "R3");
        checks++;
        if (pix_out !== 1'b0) begin
            errors++;
            $display("FAIL R3: after byte actual %b expected 0", pix_out);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        // R9: reset beats a graphics read and a sync write
        cyc(16'h4000, 8'hFF, 1'b1, 1'b1, "R9");
        cyc(16'h3FFF, 8'h00, 1'b0, 1'b1, "R9");
        cyc(16'h0000, 8'h00, 1'b1, 1'b1, "R9");
        check3("R9", 1'b0, 1'b1, 1'b1);

        byte_out(16'h4000, 8'hA5);
        byte_out(16'h8000, 8'h3C);
        byte_out(16'hC123, 8'h81);
        byte_out(16'hFFFF, 8'hFF);

        // R4: program-space reads, including the boundary addresses
        cyc(16'h3FFF, 8'hFF, 1'b1, 1'b0, "R4");
        cyc(16'h0000, 8'hFF, 1'b1, 1'b0, "R4");
        cyc(16'h3FFE, 8'hFF, 1'b1, 1'b0, "R4");
        check3("R4", 1'b0, 1'b1, 1'b1);

        // R5: graphics-range writes
        cyc(16'h4000, 8'hFF, 1'b0, 1'b0, "R5");
        cyc(16'hBFFF, 8'hFF, 1'b0, 1'b0, "R5");
        check3("R5", 1'b0, 1'b1, 1'b1);

        // R6: reload mid-byte
        cyc(16'h4000, 8'hF0, 1'b1, 1'b0, "R6");
        idle(2, "R6");
        cyc(16'h4001, 8'h0F, 1'b1, 1'b0, "R6");
        check3("R6", 1'b0, 1'b1, 1'b1);
        idle(4, "R6");
        check3("R6", 1'b1, 1'b1, 1'b1);

        idle(8, "R3");

        // R7: sync writes, upper data bits ignored
        cyc(16'h3FFF, 8'hFE, 1'b0, 1'b0, "R7");
        check3("R7", 1'b0, 1'b0, 1'b1);
        cyc(16'h3FFF, 8'h01, 1'b0, 1'b0, "R7");
        check3("R7", 1'b0, 1'b1, 1'b0);
        cyc(16'h3FFF, 8'hFC, 1'b0, 1'b0, "R7");
        check3("R7", 1'b0, 1'b0, 1'b0);

        // R8: other writes and reads of the sync address hold sync
        cyc(16'h3FFF, 8'h03, 1'b1, 1'b0, "R8");
        cyc(16'h3FFE, 8'h03, 1'b0, 1'b0, "R8");
        cyc(16'h7FFF, 8'h03, 1'b0, 1'b0, "R8");
        check3("R8", 1'b0, 1'b0, 1'b0);
        cyc(16'h3FFF, 8'h03, 1'b0, 1'b0, "R7");
        check3("R7", 1'b0, 1'b1, 1'b1);

        // R10: 80 loads spaced by 8 clocks form one 640-pixel line
        for (int n = 0; n < 80; n++) begin
            logic [7:0] b;
            b = 8'($urandom);
            cyc(16'h4000 + 16'(n), b, 1'b1, 1'b0, "R10");
            for (int k = 0; k < 7; k++) begin
                checks++;
                if (pix_out !== b[7 - k]) begin
                    errors++;
                    $display("FAIL R10: byte %0d bit %0d actual %b expected %b",
                             n, 7 - k, pix_out, b[7 - k]);
                end
                cyc(16'h0300, 8'h00, 1'b1, 1'b0, "R10");
            end
            checks++;
            if (pix_out !== b[0]) begin
                errors++;
                $display("FAIL R10: byte %0d bit 0 actual %b expected %b", n, pix_out, b[0]);
            end
        end

        // Random mix of address classes, checked every cycle
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic [1:0]  sel;
            sel = 2'($urandom);
            case (sel)
                2'd0:    a = 16'h4000 | 16'($urandom);
                2'd1:    a = 16'h3FFF;
                default: a = 16'($urandom) & 16'h3FFF;
            endcase
            cyc(a, 8'($urandom), 1'($urandom), ($urandom % 64) == 0, "R2");
        end

        // R9: reset mid-stream
        cyc(16'h4000, 8'hFF, 1'b1, 1'b0, "R9");
        cyc(16'h3FFF, 8'h00, 1'b0, 1'b0, "R9");
        cyc(16'h0000, 8'h00, 1'b1, 1'b1, "R9");
        check3("R9", 1'b0, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule